// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address a synchronous memory uses on each beat of a four-beat burst. A load cycle captures a full external address. An advance cycle steps only the two lowest address bits to the next beat of the burst. The upper bits stay fixed, so a burst never leaves its aligned group of four words. A static order select picks one of two stepping rules. The linear rule adds the beat number to the starting low bits modulo four. The interleaved rule XORs the starting low bits with the beat number.

Every input is sampled on the rising edge of one clock. An active-low clock enable freezes the block: while the enable is high, every other synchronous input is ignored and the address and beat count hold. A synchronous reset clears the state. The address output is registered and is valid in the cycle after the edge that updated it. The block has no data stream, so it uses no valid/ready handshake and all of its pins are plain control and status pins.

Top module: `burst_addr_seq`

## Requirements
- R1: When `rst` is high at a rising edge, `cur_addr` becomes 0 and the beat count becomes 0 after that edge. Reset takes priority over the clock enable.
- R2: When `cke_n` is low and `adv_ld` is low at a rising edge, `cur_addr` equals `ext_addr` after that edge, and the beat count becomes 0.
- R3: When `cke_n` is low and `adv_ld` is high at a rising edge, bits [AW-1:2] of `cur_addr` are unchanged after that edge.
- R4: With `order_sel`=0 (linear), the k-th advance after a load gives `cur_addr[1:0]` = (start + k) mod 4, where start is the loaded low two bits.
- R5: With `order_sel`=1 (interleaved), the k-th advance after a load gives `cur_addr[1:0]` = start XOR (k mod 4). For a start of 1 this gives the sequence 1,0,3,2.
- R6: After four advances, `cur_addr[1:0]` returns to the start value and later advances keep repeating the sequence, with no carry into the upper bits.
- R7: When `cke_n` is high at a rising edge (and `rst` is low), `cur_addr` and the beat count keep their values, whatever `adv_ld`, `ext_addr` and `order_sel` are doing.
- R8: `order_sel` is sampled at every enabled advance edge, and the low bits are always computed from the stored start bits and the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Active-low clock enable; high freezes all state |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load `ext_addr` |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| ext_addr | input | AW | External word address to load |
| cur_addr | output | AW | Current beat word address (registered) |

## Verification
Every result appears one edge after the edge that sampled its stimulus, because `cur_addr` sits directly behind a single register stage. The bench drives inputs on the falling edge, lets one rising edge pass, and compares `cur_addr` at the next falling edge. For a frozen cycle, the bench checks that the value is the same one it saw before that cycle. The vector table pairs each set of inputs with the address expected after the following edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  load,
  output beat_t beat
);
  always_ff @(posedge clk) begin
    if (rst)       beat <= '0;
    else if (en) begin
      if (load)    beat <= '0;
      else         beat <= beat + beat_t'(1);
    end
  end

  // R1: reset clears the beat count
  p_beat_reset_r1: assert property (@(posedge clk) rst |=> beat == '0);
  // R7: the count holds while the clock enable is off
  p_beat_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(beat));
endmodule

// File: rtl/burst_low_calc.sv
module burst_low_calc
  import burst_seq_pkg::*;
(
  input  beat_t  start,
  input  beat_t  next_beat,
  input  order_e order,
  output beat_t  low
);
  always_comb begin
    unique case (order)
      ORD_INTERLEAVE: low = start ^ next_beat;
      default:        low = start + next_beat;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cke_n,
  input  logic          adv_ld,
  input  logic          order_sel,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cur_addr
);
  localparam int unsigned UPW = AW - BEAT_W;

  logic          en;
  logic          load;
  beat_t         beat;
  beat_t         start_q;
  beat_t         low_nxt;
  logic [UPW-1:0] upper_q;
  beat_t         low_q;

  assign en   = !cke_n;
  assign load = !adv_ld;

  burst_beat_ctr u_ctr (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .load(load),
    .beat(beat)
  );

  burst_low_calc u_calc (
    .start    (start_q),
    .next_beat(beat + beat_t'(1)),
    .order    (order_e'(order_sel)),
    .low      (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      start_q <= '0;
      low_q   <= '0;
    end else if (en) begin
      if (load) begin
        upper_q <= ext_addr[AW-1:BEAT_W];
        start_q <= ext_addr[BEAT_W-1:0];
        low_q   <= ext_addr[BEAT_W-1:0];
      end else begin
        low_q   <= low_nxt;
      end
    end
  end

  assign cur_addr = {upper_q, low_q};

  // R1: reset clears the address
  p_addr_reset_r1: assert property (@(posedge clk) rst |=> cur_addr == '0);
  // R2: a load captures the external address
  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (en && load) |=> cur_addr == $past(ext_addr));
  // R3: the upper bits do not move on an advance
  p_upper_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> cur_addr[AW-1:BEAT_W] == $past(cur_addr[AW-1:BEAT_W]));
  // R7: the address holds while the clock enable is off
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cur_addr));
  // R5: in interleaved order, one step from the start flips bit 0
  p_ilv_first_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !load && order_sel && beat == '0) |=>
      cur_addr[BEAT_W-1:0] == ($past(cur_addr[BEAT_W-1:0]) ^ beat_t'(1)));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 17;
  localparam int NV = 14;

  logic clk = 0, rst = 1, cke_n = 1, adv_ld = 0, order_sel = 0;
  logic [AW-1:0] ext_addr = '0;
  wire  [AW-1:0] cur_addr;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  burst_addr_seq #(.AW(AW)) i_burst_addr_seq (
    .clk, .rst, .cke_n, .adv_ld, .order_sel, .ext_addr, .cur_addr);

  // each vector: {cke_n, adv_ld, order_sel, ext_addr, expected}
  typedef struct packed {
    logic c; logic a; logic o; logic [AW-1:0] ea; logic [AW-1:0] exp;
  } vec_t;
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b0,1'b0,17'h1_2345,17'h1_2345},  // R2 load, start 1
    '{1'b0,1'b1,1'b0,17'h0,17'h1_2346},       // R4 linear k1 = 2
    '{1'b0,1'b1,1'b0,17'h0,17'h1_2347},       // R4 k2 = 3
    '{1'b0,1'b1,1'b0,17'h0,17'h1_2344},       // R4 k3 = 0 wrap, R3 no carry
    '{1'b0,1'b1,1'b0,17'h0,17'h1_2345},       // R6 back to start
    '{1'b0,1'b1,1'b0,17'h0,17'h1_2346},       // R6 repeats
    '{1'b0,1'b0,1'b1,17'h0_0A11,17'h0_0A11},  // R2 load, start 1
    '{1'b0,1'b1,1'b1,17'h0,17'h0_0A10},       // R5 interleaved: 0
    '{1'b0,1'b1,1'b1,17'h0,17'h0_0A13},       // R5: 3
    '{1'b0,1'b1,1'b1,17'h0,17'h0_0A12},       // R5: 2
    '{1'b0,1'b1,1'b1,17'h0,17'h0_0A11},       // R6 wraps to start
    '{1'b1,1'b0,1'b0,17'h1_FFFF,17'h0_0A11},  // R7 frozen, load ignored
    '{1'b1,1'b1,1'b1,17'h0,17'h0_0A11},       // R7 frozen, advance ignored
    '{1'b0,1'b1,1'b1,17'h0,17'h0_0A10}        // R7 count kept (k1)
  };

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic c, logic a, logic o, logic [AW-1:0] ea);
    cke_n = c; adv_ld = a; order_sel = o; ext_addr = ea;
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset", cur_addr, '0);
    rst = 0;
    for (int i = 0; i < NV; i++) begin
      step(VT[i].c, VT[i].a, VT[i].o, VT[i].ea);
      chk($sformatf("R2-7 vec%0d", i), cur_addr, VT[i].exp);
    end
    // R8: order changes mid burst; linear from start 2, then interleaved at k2
    step(0, 0, 0, 17'h0_0302);
    step(0, 1, 0, '0); chk("R8 linear k1", cur_addr, 17'h0_0303);
    step(0, 1, 1, '0); chk("R8 ilv k2", cur_addr, 17'h0_0300);
    // R3: top address, advance must not carry
    step(0, 0, 0, 17'h1_FFFF);
    step(0, 1, 0, '0); chk("R3 no carry", cur_addr, 17'h1_FFFC);
    // R1: reset wins over a frozen clock enable
    rst = 1; step(1, 1, 0, '0); chk("R1 reset over cke", cur_addr, '0);
    rst = 0;
    step(0, 1, 0, '0); chk("R1 beat cleared", cur_addr, 17'h0_0001);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule